// File: doc/BRIEF.md
# Virtual Channel Table Manager

This block is the hardware service unit that keeps the registry of communication channels used by hardware tasks. A task posts a service request carrying a service identifier, an operation, a channel name, its own task address, whether it is a hardware task, and an optional timeout in clock cycles. Requests wait in a small first-in first-out queue. A router in front of the decoder passes on only the requests whose service identifier matches the channel service, and silently drops all others.

A decoding state machine takes one request at a time. It looks the channel name up in an on-chip table and updates the matching entry. An entry holds the name, an identifier given out automatically, one sender record, and a bounded set of receiver records. Each receiver record has a flag that marks a pending receive apart from a plain registration, and the entry keeps a running receiver count for broadcast. Every request gets exactly one response. The response carries a status code, the channel identifier, the peer task address, and a transfer-mode bit. The mode bit tells the caller to move data directly or through a buffer in global memory. When the peer is absent, the caller either gets a timeout after the requested number of cycles or is told to go through the buffer. Data movement and buffer allocation are done elsewhere.

Top module: `vc_table_mgr`

## Requirements
- R1: Requests are accepted on any cycle where req_valid and req_ready are both high, and are served strictly in arrival order. Up to FIFO_DEPTH requests may be queued back to back. After reset req_ready is 1 and rsp_valid is 0.
- R2: A request whose req_svc differs from MW_SVC is removed from the queue with no response and no effect on the table.
- R3: Operation codes are 0 open-as-sender, 1 open-as-receiver, 2 send, 3 receive, 4 end-of-communication and 5 close. The first open of an unknown name creates an entry. Identifiers are handed out in creation order starting at 1 (1, 2, 3 and so on). An open of a known name reuses that entry and its identifier.
- R4: A channel holds one sender. Open-as-sender by a different task while a sender is held returns status 5 (busy), with rsp_peer set to the current sender. Otherwise the requester becomes the sender, and rsp_peer is the lowest-index receiver, or 0 if there is none.
- R5: Open-as-receiver and receive register the requester as a receiver if it is not yet registered. The receive request sets that record's pending flag. The entry's receiver count always equals its number of receiver records. Registering a receiver beyond N_DST returns status 6 (no receiver slot).
- R6: End-of-communication by a registered receiver clears its pending flag and returns status 0 (ok). From an unregistered task it returns status 7 (not registered).
- R7: A send with no receiver, or a receive with neither a sender nor buffered data, returns status 2 (timeout) when req_tmo is nonzero. That response comes exactly req_tmo cycles later than an immediate response would.
- R8: The same absent-peer cases with req_tmo = 0 return status 1 (buffered) with rsp_mode 1, and a send marks the entry as holding buffered data. The next receive on that entry returns status 0, rsp_mode 1 and the sender as peer, and clears the mark.
- R9: When the peer is present, rsp_mode is 0 (direct) if the receiver is a hardware task and 1 (buffered) if it is a software task. A send reports the lowest-index receiver as peer, and a receive reports the sender.
- R10: Close removes the requester's sender or receiver record and returns status 0. A task holding neither record gets status 7. The entry is deleted once no sender and no receivers remain, and later requests on that name return status 4 (no channel).
- R11: Opening an unknown name while all N_CH entries are in use returns status 3 (table full) with identifier 0 and leaves the table unchanged.
- R12: Each forwarded request yields exactly one single-cycle rsp_valid pulse, two cycles after acceptance when no timeout runs. Send, receive, end or close on an unknown name returns status 4 with identifier 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Queue can take a request |
| req_svc | input | SVC_W | Service identifier of the request |
| req_op | input | 3 | Operation code |
| req_name | input | NAME_W | Channel name |
| req_task | input | TASK_W | Requesting task address |
| req_hw | input | 1 | Requester is a hardware task |
| req_tmo | input | TMO_W | Timeout in cycles, 0 for none |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 4 | Status code |
| rsp_id | output | ID_W | Channel identifier, 0 if none |
| rsp_peer | output | TASK_W | Peer task address, 0 if none |
| rsp_mode | output | 1 | 0 direct transfer, 1 through global buffer |

## Verification
On every cycle the assertions check several invariants. The queue never overflows or underflows, and each entry's receiver count matches its receiver records. Every live entry holds a nonzero identifier. A response is a single pulse issued with the machine back at idle, and a timeout status only ever follows the waiting state. The table behaviours can only be shown by the bench's request sequences: identifier reuse, the single-sender rule, the direct-or-buffered decision, buffered hand-over, deletion on last close, the full table, and the exact timeout latency. The bench also shows that a foreign-service request leaves no trace and that queued requests answer in order.

// File: rtl/vct_pkg.sv
package vct_pkg;

   typedef enum logic [2:0] {
      OP_OPEN_TX = 3'd0,
      OP_OPEN_RX = 3'd1,
      OP_SEND    = 3'd2,
      OP_RECV    = 3'd3,
      OP_END     = 3'd4,
      OP_CLOSE   = 3'd5
   } vct_op_e;

   typedef enum logic [3:0] {
      ST_OK       = 4'd0,
      ST_BUFFERED = 4'd1,
      ST_TIMEOUT  = 4'd2,
      ST_FULL     = 4'd3,
      ST_NOCHAN   = 4'd4,
      ST_BUSY     = 4'd5,
      ST_NODEST   = 4'd6,
      ST_NOTREG   = 4'd7,
      ST_BADOP    = 4'd8
   } vct_st_e;

   typedef enum logic [1:0] {
      E_IDLE = 2'd0,
      E_EXEC = 2'd1,
      E_WAIT = 2'd2
   } vct_fsm_e;

endpackage

// File: rtl/vct_req_fifo.sv
module vct_req_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("vct_req_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] cnt;

   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));
   assign dout  = mem[rp];

   function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (push) begin
            mem[wp] <= din;
            wp      <= inc(wp);
         end
         if (pop) rp <= inc(rp);
         if (push && !pop)      cnt <= cnt + 1'b1;
         else if (pop && !push) cnt <= cnt - 1'b1;
      end
   end

   assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (cnt < CW'(DEPTH)));
   assert_no_underflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (cnt != '0));

endmodule

// File: rtl/vct_engine.sv
module vct_engine
   import vct_pkg::*;
#(
   parameter int N_CH   = 4,
   parameter int N_DST  = 3,
   parameter int NAME_W = 8,
   parameter int TASK_W = 8,
   parameter int ID_W   = 4,
   parameter int TMO_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [2:0]        cmd_op,
   input  logic [NAME_W-1:0] cmd_name,
   input  logic [TASK_W-1:0] cmd_task,
   input  logic              cmd_hw,
   input  logic [TMO_W-1:0]  cmd_tmo,
   output logic              rsp_valid,
   output logic [3:0]        rsp_status,
   output logic [ID_W-1:0]   rsp_id,
   output logic [TASK_W-1:0] rsp_peer,
   output logic              rsp_mode
);
   localparam int CIW = $clog2(N_CH);
   localparam int DIW = (N_DST > 1) ? $clog2(N_DST) : 1;
   localparam int DCW = $clog2(N_DST + 1);

   if (N_CH < 2) begin : g_bad_nch
      $error("vct_engine: N_CH must be at least 2");
   end
   if (N_CH >= (1 << ID_W)) begin : g_bad_idw
      $error("vct_engine: ID_W too narrow for N_CH live identifiers");
   end

   // channel table
   logic [N_CH-1:0]   c_val, c_tx, c_buf;
   logic [NAME_W-1:0] c_name [N_CH];
   logic [ID_W-1:0]   c_id   [N_CH];
   logic [TASK_W-1:0] c_txt  [N_CH];
   logic [N_DST-1:0]  d_val  [N_CH];
   logic [N_DST-1:0]  d_hw   [N_CH];
   logic [N_DST-1:0]  d_pnd  [N_CH];
   logic [TASK_W-1:0] d_task [N_CH][N_DST];
   logic [DCW-1:0]    d_cnt  [N_CH];
   logic [ID_W-1:0]   next_id;

   // current request
   vct_fsm_e          st;
   vct_op_e           cur_op;
   logic [NAME_W-1:0] cur_name;
   logic [TASK_W-1:0] cur_task;
   logic              cur_hw;
   logic [TMO_W-1:0]  cur_tmo, tcnt;

   assign cmd_ready = (st == E_IDLE);

   // lookup
   logic           hit, free, any_dst, me_dst, dfree;
   logic [CIW-1:0] hit_ix, free_ix, sel;
   logic [DIW-1:0] first_ix, me_ix, dfree_ix;

   always_comb begin
      hit = 1'b0; hit_ix = '0; free = 1'b0; free_ix = '0;
      for (int i = N_CH - 1; i >= 0; i--) begin
         if (c_val[i] && c_name[i] == cur_name) begin hit = 1'b1; hit_ix = CIW'(i); end
         if (!c_val[i]) begin free = 1'b1; free_ix = CIW'(i); end
      end
      sel = hit ? hit_ix : free_ix;
      any_dst = |d_val[sel];
      me_dst = 1'b0; me_ix = '0; dfree = 1'b0; dfree_ix = '0; first_ix = '0;
      for (int j = N_DST - 1; j >= 0; j--) begin
         if (d_val[sel][j]) first_ix = DIW'(j);
         if (d_val[sel][j] && d_task[sel][j] == cur_task) begin me_dst = 1'b1; me_ix = DIW'(j); end
         if (!d_val[sel][j]) begin dfree = 1'b1; dfree_ix = DIW'(j); end
      end
   end

   // decision
   vct_st_e           r_st;
   logic              r_mode, wait_req;
   logic [TASK_W-1:0] r_peer;
   logic [ID_W-1:0]   r_id;
   logic do_create, set_tx, clr_tx, add_dst, add_pnd, pend_set, pend_clr;
   logic rem_dst, set_buf, clr_buf, do_del, is_tx;
   logic [DCW-1:0] left_d;

   always_comb begin
      r_st = ST_OK; r_mode = 1'b0; r_peer = '0; wait_req = 1'b0;
      r_id = hit ? c_id[hit_ix] : '0;
      do_create = 1'b0; set_tx = 1'b0; clr_tx = 1'b0; add_dst = 1'b0; add_pnd = 1'b0;
      pend_set = 1'b0; pend_clr = 1'b0; rem_dst = 1'b0; set_buf = 1'b0; clr_buf = 1'b0;
      do_del = 1'b0;
      is_tx  = hit && c_tx[sel] && (c_txt[sel] == cur_task);
      left_d = d_cnt[sel] - DCW'(me_dst);
      case (cur_op)
         OP_OPEN_TX, OP_OPEN_RX: begin
            if (!hit && !free) r_st = ST_FULL;
            else begin
               if (!hit) begin do_create = 1'b1; r_id = next_id; end
               if (cur_op == OP_OPEN_TX) begin
                  if (hit && c_tx[sel] && !is_tx) begin r_st = ST_BUSY; r_peer = c_txt[sel]; end
                  else begin set_tx = 1'b1; r_peer = any_dst ? d_task[sel][first_ix] : '0; end
               end else begin
                  r_peer = (hit && c_tx[sel]) ? c_txt[sel] : '0;
                  if (!me_dst) begin
                     if (!dfree) r_st = ST_NODEST;
                     else add_dst = 1'b1;
                  end
               end
            end
         end
         OP_SEND: begin
            if (!hit) r_st = ST_NOCHAN;
            else if (any_dst) begin
               r_peer = d_task[sel][first_ix];
               r_mode = !d_hw[sel][first_ix];
            end else if (cur_tmo != '0) wait_req = 1'b1;
            else begin r_st = ST_BUFFERED; r_mode = 1'b1; set_buf = 1'b1; end
         end
         OP_RECV: begin
            if (!hit) r_st = ST_NOCHAN;
            else if (!me_dst && !dfree) r_st = ST_NODEST;
            else begin
               if (!me_dst) begin add_dst = 1'b1; add_pnd = 1'b1; end
               else pend_set = 1'b1;
               if (c_buf[sel]) begin
                  r_mode = 1'b1; clr_buf = 1'b1;
                  r_peer = c_tx[sel] ? c_txt[sel] : '0;
               end else if (c_tx[sel]) begin
                  r_peer = c_txt[sel]; r_mode = !cur_hw;
               end else if (cur_tmo != '0) wait_req = 1'b1;
               else begin r_st = ST_BUFFERED; r_mode = 1'b1; end
            end
         end
         OP_END: begin
            if (!hit) r_st = ST_NOCHAN;
            else if (!me_dst) r_st = ST_NOTREG;
            else pend_clr = 1'b1;
         end
         OP_CLOSE: begin
            if (!hit) r_st = ST_NOCHAN;
            else if (!is_tx && !me_dst) r_st = ST_NOTREG;
            else begin
               clr_tx  = is_tx;
               rem_dst = me_dst;
               do_del  = !(c_tx[sel] && !is_tx) && (left_d == '0);
            end
         end
         default: r_st = ST_BADOP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= E_IDLE; cur_op <= OP_OPEN_TX; cur_name <= '0; cur_task <= '0;
         cur_hw <= 1'b0; cur_tmo <= '0; tcnt <= '0; next_id <= ID_W'(1);
         rsp_valid <= 1'b0; rsp_status <= '0; rsp_id <= '0; rsp_peer <= '0; rsp_mode <= 1'b0;
         c_val <= '0; c_tx <= '0; c_buf <= '0;
         for (int i = 0; i < N_CH; i++) begin
            c_name[i] <= '0; c_id[i] <= '0; c_txt[i] <= '0; d_cnt[i] <= '0;
            d_val[i] <= '0; d_hw[i] <= '0; d_pnd[i] <= '0;
            for (int j = 0; j < N_DST; j++) d_task[i][j] <= '0;
         end
      end else begin
         rsp_valid <= 1'b0;
         case (st)
            E_IDLE: if (cmd_valid) begin
               cur_op <= vct_op_e'(cmd_op); cur_name <= cmd_name; cur_task <= cmd_task;
               cur_hw <= cmd_hw; cur_tmo <= cmd_tmo; st <= E_EXEC;
            end
            E_EXEC: begin
               rsp_status <= r_st; rsp_id <= r_id; rsp_peer <= r_peer; rsp_mode <= r_mode;
               if (wait_req) begin tcnt <= cur_tmo; st <= E_WAIT; end
               else begin rsp_valid <= 1'b1; st <= E_IDLE; end
               if (do_create) begin
                  c_val[sel] <= 1'b1; c_name[sel] <= cur_name; c_id[sel] <= next_id;
                  c_tx[sel] <= 1'b0; c_buf[sel] <= 1'b0;
                  next_id <= (next_id == '1) ? ID_W'(1) : next_id + 1'b1;
               end
               if (set_tx) begin c_tx[sel] <= 1'b1; c_txt[sel] <= cur_task; end
               if (clr_tx) c_tx[sel] <= 1'b0;
               if (set_buf) c_buf[sel] <= 1'b1;
               if (clr_buf) c_buf[sel] <= 1'b0;
               if (add_dst) begin
                  d_val[sel][dfree_ix] <= 1'b1; d_task[sel][dfree_ix] <= cur_task;
                  d_hw[sel][dfree_ix] <= cur_hw; d_pnd[sel][dfree_ix] <= add_pnd;
                  d_cnt[sel] <= d_cnt[sel] + 1'b1;
               end
               if (pend_set) d_pnd[sel][me_ix] <= 1'b1;
               if (pend_clr) d_pnd[sel][me_ix] <= 1'b0;
               if (rem_dst) begin
                  d_val[sel][me_ix] <= 1'b0; d_pnd[sel][me_ix] <= 1'b0;
                  d_cnt[sel] <= d_cnt[sel] - 1'b1;
               end
               if (do_del) begin c_val[sel] <= 1'b0; c_buf[sel] <= 1'b0; end
            end
            E_WAIT: begin
               if (tcnt == TMO_W'(1)) begin
                  rsp_valid <= 1'b1; rsp_status <= ST_TIMEOUT;
                  rsp_peer <= '0; rsp_mode <= 1'b0; st <= E_IDLE;
               end else tcnt <= tcnt - 1'b1;
            end
            default: st <= E_IDLE;
         endcase
      end
   end

   for (genvar g = 0; g < N_CH; g++) begin : g_chk
      assert_dest_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
         d_cnt[g] == DCW'($countones(d_val[g])));
      assert_live_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
         c_val[g] |-> (c_id[g] != '0));
   end

   assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   assert_rsp_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (st == E_IDLE));
   assert_timeout_after_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == ST_TIMEOUT) |-> ($past(st) == E_WAIT));

endmodule

// File: rtl/vc_table_mgr.sv
module vc_table_mgr #(
   parameter int              N_CH       = 4,
   parameter int              N_DST      = 3,
   parameter int              NAME_W     = 8,
   parameter int              TASK_W     = 8,
   parameter int              ID_W       = 4,
   parameter int              TMO_W      = 8,
   parameter int              SVC_W      = 4,
   parameter logic [SVC_W-1:0] MW_SVC    = 4'hA,
   parameter int              FIFO_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [SVC_W-1:0]  req_svc,
   input  logic [2:0]        req_op,
   input  logic [NAME_W-1:0] req_name,
   input  logic [TASK_W-1:0] req_task,
   input  logic              req_hw,
   input  logic [TMO_W-1:0]  req_tmo,
   output logic              rsp_valid,
   output logic [3:0]        rsp_status,
   output logic [ID_W-1:0]   rsp_id,
   output logic [TASK_W-1:0] rsp_peer,
   output logic              rsp_mode
);
   localparam int FW = SVC_W + 3 + NAME_W + TASK_W + 1 + TMO_W;

   logic [FW-1:0]     q_din, q_dout;
   logic              q_empty, q_full, q_push, q_pop;
   logic [SVC_W-1:0]  h_svc;
   logic [2:0]        h_op;
   logic [NAME_W-1:0] h_name;
   logic [TASK_W-1:0] h_task;
   logic              h_hw, h_mw, eng_ready, cmd_valid;
   logic [TMO_W-1:0]  h_tmo;

   assign req_ready = !q_full;
   assign q_push    = req_valid && req_ready;
   assign q_din     = {req_svc, req_op, req_name, req_task, req_hw, req_tmo};

   vct_req_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(q_push), .din(q_din), .pop(q_pop),
      .dout(q_dout), .empty(q_empty), .full(q_full)
   );

   // service routing: foreign requests are dropped without waiting for the engine
   assign {h_svc, h_op, h_name, h_task, h_hw, h_tmo} = q_dout;
   assign h_mw      = (h_svc == MW_SVC);
   assign cmd_valid = !q_empty && h_mw && eng_ready;
   assign q_pop     = !q_empty && (!h_mw || eng_ready);

   vct_engine #(
      .N_CH(N_CH), .N_DST(N_DST), .NAME_W(NAME_W), .TASK_W(TASK_W),
      .ID_W(ID_W), .TMO_W(TMO_W)
   ) u_engine (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(eng_ready),
      .cmd_op(h_op), .cmd_name(h_name), .cmd_task(h_task), .cmd_hw(h_hw), .cmd_tmo(h_tmo),
      .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_id(rsp_id),
      .rsp_peer(rsp_peer), .rsp_mode(rsp_mode)
   );

   assert_forward_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (q_pop && h_svc == MW_SVC));

endmodule

// File: tb/vc_table_mgr_bench.sv
module vc_table_mgr_bench;
   import vct_pkg::*;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [3:0] req_svc = 4'hA;
   logic [2:0] req_op = '0;
   logic [7:0] req_name = '0, req_task = '0, req_tmo = '0;
   logic       req_hw = 1'b0;
   logic       rsp_valid, rsp_mode;
   logic [3:0] rsp_status, rsp_id;
   logic [7:0] rsp_peer;

   int checks = 0, fails = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   vc_table_mgr u_vc_table_mgr (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_svc(req_svc), .req_op(req_op), .req_name(req_name), .req_task(req_task),
      .req_hw(req_hw), .req_tmo(req_tmo), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
      .rsp_id(rsp_id), .rsp_peer(rsp_peer), .rsp_mode(rsp_mode)
   );

   typedef struct packed {
      logic [2:0] op; logic [7:0] name; logic [7:0] tsk; logic hw; logic [7:0] tmo;
      logic [3:0] st; logic [3:0] id; logic [7:0] peer; logic mode; logic [3:0] req;
   } vec_t;

   localparam int NV = 29;
   localparam vec_t VECS [NV] = '{
      '{OP_OPEN_RX, 8'h11, 8'h31, 1'b1, 8'd0, ST_OK,       4'd1, 8'h00, 1'b0, 4'd3},  // R3 create
      '{OP_SEND,    8'h11, 8'h40, 1'b0, 8'd0, ST_OK,       4'd1, 8'h31, 1'b0, 4'd9},  // R9 hw rx direct
      '{OP_OPEN_TX, 8'h11, 8'h40, 1'b0, 8'd0, ST_OK,       4'd1, 8'h31, 1'b0, 4'd3},  // R3 reuse
      '{OP_OPEN_TX, 8'h11, 8'h41, 1'b0, 8'd0, ST_BUSY,     4'd1, 8'h40, 1'b0, 4'd4},  // R4
      '{OP_OPEN_RX, 8'h11, 8'h32, 1'b0, 8'd0, ST_OK,       4'd1, 8'h40, 1'b0, 4'd5},  // R5
      '{OP_RECV,    8'h11, 8'h32, 1'b0, 8'd0, ST_OK,       4'd1, 8'h40, 1'b1, 4'd9},  // R9 sw rx
      '{OP_RECV,    8'h11, 8'h31, 1'b1, 8'd0, ST_OK,       4'd1, 8'h40, 1'b0, 4'd9},  // R9 hw rx
      '{OP_OPEN_TX, 8'h22, 8'h50, 1'b1, 8'd0, ST_OK,       4'd2, 8'h00, 1'b0, 4'd3},  // R3 id 2
      '{OP_SEND,    8'h22, 8'h50, 1'b1, 8'd0, ST_BUFFERED, 4'd2, 8'h00, 1'b1, 4'd8},  // R8
      '{OP_RECV,    8'h22, 8'h33, 1'b1, 8'd0, ST_OK,       4'd2, 8'h50, 1'b1, 4'd8},  // R8 hand-over
      '{OP_SEND,    8'h22, 8'h50, 1'b1, 8'd0, ST_OK,       4'd2, 8'h33, 1'b0, 4'd9},  // R9
      '{OP_OPEN_RX, 8'h22, 8'h34, 1'b0, 8'd0, ST_OK,       4'd2, 8'h50, 1'b0, 4'd5},  // R5
      '{OP_RECV,    8'h22, 8'h35, 1'b0, 8'd0, ST_OK,       4'd2, 8'h50, 1'b1, 4'd8},  // R8 mark cleared
      '{OP_OPEN_RX, 8'h22, 8'h36, 1'b0, 8'd0, ST_NODEST,   4'd2, 8'h50, 1'b0, 4'd5},  // R5 limit
      '{OP_END,     8'h22, 8'h35, 1'b0, 8'd0, ST_OK,       4'd2, 8'h00, 1'b0, 4'd6},  // R6
      '{OP_END,     8'h22, 8'h77, 1'b0, 8'd0, ST_NOTREG,   4'd2, 8'h00, 1'b0, 4'd6},  // R6
      '{OP_SEND,    8'h77, 8'h40, 1'b0, 8'd0, ST_NOCHAN,   4'd0, 8'h00, 1'b0, 4'd12}, // R12
      '{OP_CLOSE,   8'h11, 8'h99, 1'b0, 8'd0, ST_NOTREG,   4'd1, 8'h00, 1'b0, 4'd10}, // R10
      '{OP_CLOSE,   8'h11, 8'h40, 1'b0, 8'd0, ST_OK,       4'd1, 8'h00, 1'b0, 4'd10}, // R10
      '{OP_RECV,    8'h11, 8'h31, 1'b1, 8'd0, ST_BUFFERED, 4'd1, 8'h00, 1'b1, 4'd8},  // R8 no sender
      '{OP_CLOSE,   8'h11, 8'h31, 1'b1, 8'd0, ST_OK,       4'd1, 8'h00, 1'b0, 4'd10}, // R10
      '{OP_CLOSE,   8'h11, 8'h32, 1'b0, 8'd0, ST_OK,       4'd1, 8'h00, 1'b0, 4'd10}, // R10 last
      '{OP_SEND,    8'h11, 8'h40, 1'b0, 8'd0, ST_NOCHAN,   4'd0, 8'h00, 1'b0, 4'd10}, // R10 deleted
      '{OP_OPEN_TX, 8'h33, 8'h60, 1'b0, 8'd0, ST_OK,       4'd3, 8'h00, 1'b0, 4'd3},  // R3
      '{OP_OPEN_TX, 8'h44, 8'h61, 1'b0, 8'd0, ST_OK,       4'd4, 8'h00, 1'b0, 4'd3},  // R3
      '{OP_OPEN_TX, 8'h55, 8'h62, 1'b0, 8'd0, ST_OK,       4'd5, 8'h00, 1'b0, 4'd3},  // R3
      '{OP_OPEN_TX, 8'h66, 8'h63, 1'b0, 8'd0, ST_FULL,     4'd0, 8'h00, 1'b0, 4'd11}, // R11
      '{OP_OPEN_RX, 8'h66, 8'h63, 1'b0, 8'd0, ST_FULL,     4'd0, 8'h00, 1'b0, 4'd11}, // R11
      '{OP_SEND,    8'h66, 8'h63, 1'b0, 8'd0, ST_NOCHAN,   4'd0, 8'h00, 1'b0, 4'd11}  // R11 unchanged
   };

   logic [3:0] a_st, a_id;
   logic [7:0] a_peer;
   logic       a_mode;
   int         a_lat;

   task automatic check(input bit ok, input string tag, input logic [16:0] act, input logic [16:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic push(input logic [3:0] svc, input logic [2:0] op, input logic [7:0] nm,
                       input logic [7:0] tk, input logic hw, input logic [7:0] tmo);
      req_valid = 1'b1; req_svc = svc; req_op = op; req_name = nm;
      req_task = tk; req_hw = hw; req_tmo = tmo;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_rsp();
      a_lat = 0;
      while (!rsp_valid && a_lat < 400) begin
         @(negedge clk);
         a_lat++;
      end
      a_st = rsp_status; a_id = rsp_id; a_peer = rsp_peer; a_mode = rsp_mode;
   endtask

   task automatic do_req(input logic [3:0] svc, input logic [2:0] op, input logic [7:0] nm,
                         input logic [7:0] tk, input logic hw, input logic [7:0] tmo);
      push(svc, op, nm, tk, hw, tmo);
      wait_rsp();
      @(negedge clk);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
   end

   initial begin
      logic [16:0] got [3];
      int          n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(req_ready === 1'b1 && rsp_valid === 1'b0, "R1 reset", {15'd0, req_ready, rsp_valid}, 17'd2);

      for (int v = 0; v < NV; v++) begin
         do_req(4'hA, VECS[v].op, VECS[v].name, VECS[v].tsk, VECS[v].hw, VECS[v].tmo);
         check({a_st, a_id, a_peer, a_mode} === {VECS[v].st, VECS[v].id, VECS[v].peer, VECS[v].mode},
               $sformatf("R%0d vector %0d", VECS[v].req, v),
               {a_st, a_id, a_peer, a_mode}, {VECS[v].st, VECS[v].id, VECS[v].peer, VECS[v].mode});
         check(a_lat == 2, $sformatf("R12 latency vector %0d", v), 17'(a_lat), 17'd2);
      end

      // R7 timeout with tmo = 5 and tmo = 1
      do_req(4'hA, OP_SEND, 8'h33, 8'h60, 1'b0, 8'd5);
      check(a_st == ST_TIMEOUT && a_id == 4'd3, "R7 timeout status", {a_st, a_id, 9'd0}, {ST_TIMEOUT, 4'd3, 9'd0});
      check(a_lat == 7, "R7 timeout latency 5", 17'(a_lat), 17'd7);
      do_req(4'hA, OP_SEND, 8'h44, 8'h61, 1'b0, 8'd1);
      check(a_st == ST_TIMEOUT && a_id == 4'd4, "R7 timeout status", {a_st, a_id, 9'd0}, {ST_TIMEOUT, 4'd4, 9'd0});
      check(a_lat == 3, "R7 timeout latency 1", 17'(a_lat), 17'd3);

      // R2 foreign service close is dropped; channel 0x55 survives
      push(4'h3, OP_CLOSE, 8'h55, 8'h62, 1'b0, 8'd0);
      n = 0;
      for (int c = 0; c < 6; c++) begin
         if (rsp_valid) n++;
         @(negedge clk);
      end
      check(n == 0, "R2 no response", 17'(n), 17'd0);
      do_req(4'hA, OP_SEND, 8'h55, 8'h62, 1'b0, 8'd0);
      check(a_st == ST_BUFFERED && a_id == 4'd5, "R2 table untouched", {a_st, a_id, 9'd0}, {ST_BUFFERED, 4'd5, 9'd0});

      // R1 three back-to-back requests answered in order
      req_valid = 1'b1; req_svc = 4'hA; req_op = OP_SEND; req_name = 8'h22; req_task = 8'h50; req_hw = 1'b1; req_tmo = 8'd0;
      @(negedge clk);
      req_name = 8'h33; req_task = 8'h60;
      @(negedge clk);
      req_name = 8'h77;
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      for (int c = 0; c < 20; c++) begin
         if (rsp_valid && n < 3) begin
            got[n] = {rsp_status, rsp_id, rsp_peer, rsp_mode};
            n++;
         end
         @(negedge clk);
      end
      check(n == 3, "R1 response count", 17'(n), 17'd3);
      check(got[0] === {ST_OK, 4'd2, 8'h33, 1'b0}, "R1 order first", got[0], {ST_OK, 4'd2, 8'h33, 1'b0});
      check(got[1] === {ST_BUFFERED, 4'd3, 8'h00, 1'b1}, "R1 order second", got[1], {ST_BUFFERED, 4'd3, 8'h00, 1'b1});
      check(got[2] === {ST_NOCHAN, 4'd0, 8'h00, 1'b0}, "R1 order third", got[2], {ST_NOCHAN, 4'd0, 8'h00, 1'b0});

      summary();
   end

endmodule